// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block holds the per-interrupt configuration and status of a multi-processor interrupt controller. For every interrupt ID it keeps the enable, pending, priority, CPU-target and trigger-configuration state. Entries for IDs below 32 are private to each CPU where the requirements say so. It turns external level inputs into pending state, and it decodes a word write that raises a software interrupt through a target filter. All state is exported as flat vectors to the downstream selection logic, which also returns the active bits for read-back.

Software reaches the block through a single register port. A request carries a 12-bit byte offset, a byte/word size flag and the number of the requesting CPU. A small access state machine has two states, `ST_IDLE` and `ST_RESP`. A request in `ST_IDLE` is accepted, its write takes effect and the machine moves to `ST_RESP` (transition *accept*). In `ST_RESP` it presents the read data and error flag for one cycle, then returns to `ST_IDLE` unconditionally (transition *return*).

Top module: `irq_dist_regs`

## Requirements
- R1: A request is accepted only while `req_ready` is high (state `ST_IDLE`). In the next cycle `rsp_valid` is high for exactly one cycle and `req_ready` is low. A byte access returns its data in `rsp_rdata[7:0]` with the upper bits zero. A word access covers offsets `{addr[11:2],00}` to `+3`, with lane k in bits `[8k+7:8k]`.
- R2: Offset 0x000 bit 0 is the global enable (`dist_en_o`) and can be read back. Offset 0x004 reads (NUM_IRQ/32 − 1) in bits [4:0] and (NUM_CPU − 1) from bit 5. Offsets 0x001–0x007 other than these read zero and ignore writes.
- R3: Writing ones to byte 0x100+k sets the enables of IDs 8k..8k+7, and writing ones to byte 0x180+k clears them. Enables of IDs below 32 belong to the requesting CPU only. Higher IDs are shared by all CPUs. IDs 0–15 are enabled for all CPUs from reset and can never be cleared.
- R4: Setting the enable of a level-configured external interrupt whose input is high makes it pending for its target CPUs.
- R5: Byte 0x200+k sets and byte 0x280+k clears pending bits, with bit i standing for ID 8k+i. A set is ignored for IDs 0–15, applies to the requester for IDs 16–31, and applies to the targets for higher IDs. A clear applies to all CPUs. Reads of the enable and pending windows show the requester's bit for IDs below 32 and the OR over all CPUs for higher IDs.
- R6: Byte 0x400+id is that ID's priority. It is held per CPU for IDs below 32 and shared for higher IDs.
- R7: Byte 0x800+id is that ID's CPU-target mask. IDs below 29 store zero. IDs 29–31 store all CPUs but read back only the requester's bit. Higher IDs store the low NUM_CPU bits written.
- R8: Byte 0xC00+k configures IDs 4k..4k+3. Bit 2i selects the one-of-N model and bit 2i+1 selects edge triggering. A write covering IDs below 32 always sets the edge bits. IDs 0–15 are edge-triggered from reset.
- R9: External line n drives ID n+32. When the line goes high, the ID becomes pending for its targets if it is edge-triggered or enabled. A high-to-low change only drops the stored level, and a line held high does not re-trigger.
- R10: A word write to 0xF00 sets pending for the ID in bits [9:0]. Bits [25:24] pick the CPUs: 0 = the mask in bits [23:16], 1 = all except the writer, 2 = the writer only, 3 = all.
- R11: Bytes 0x300+k read the active bits from `active_i`, with the same per-CPU and OR rule as R5. Writes there are ignored without error.
- R12: Offsets outside every window, window bytes for IDs at or above NUM_IRQ, byte or read accesses to 0xF00, and 0xF04–0xFFF read zero and ignore writes. They raise `rsp_err` in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit access, 0 = byte |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 32 | Write data |
| req_cpu | input | CPU_W | Requesting CPU number |
| req_ready | output | 1 | Request can be accepted |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Unmapped access flag |
| ext_irq | input | NUM_IRQ-32 | External level inputs |
| active_i | input | NUM_CPU*NUM_IRQ | Active bits from the selector, index cpu*NUM_IRQ+id |
| dist_en_o | output | 1 | Global enable |
| enable_o | output | NUM_CPU*NUM_IRQ | Enable bits, index cpu*NUM_IRQ+id |
| pending_o | output | NUM_CPU*NUM_IRQ | Pending bits, index cpu*NUM_IRQ+id |
| prio_o | output | NUM_CPU*NUM_IRQ*8 | Priorities, byte cpu*NUM_IRQ+id |
| target_o | output | NUM_IRQ*NUM_CPU | Target masks, index id*NUM_CPU+cpu |
| model_o | output | NUM_IRQ | One-of-N model bits |
| edge_o | output | NUM_IRQ | Edge-trigger bits |

## Verification
On every cycle the embedded properties check four things. The response lasts exactly one cycle and blocks new requests. IDs 0–15 stay enabled and edge-triggered. Targets below ID 29 stay zero. An edge-triggered input that goes high with no access in flight makes its ID pending for every target in the following cycle. The directed scenarios check the behaviour that depends on the requesting CPU or on ordering: per-CPU enables and priorities, the four software-interrupt filters, the pending triggered by an enable on a high level input, no re-trigger while a line stays high, and error responses on unmapped offsets that leave the state untouched.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    typedef enum logic {ST_IDLE, ST_RESP} acc_state_t;

    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_ALL    = 2'd3
    } sw_filter_t;

    localparam logic [11:0] OFF_SWINT   = 12'hF00;
    localparam logic [11:0] WIN_ENABLE  = 12'h100;
    localparam logic [11:0] WIN_PENDING = 12'h200;
    localparam logic [11:0] WIN_ACTIVE  = 12'h300;
    localparam logic [11:0] WIN_PRIO    = 12'h400;
    localparam logic [11:0] WIN_TARGET  = 12'h800;
    localparam logic [11:0] WIN_CONFIG  = 12'hC00;
    localparam logic [11:0] WIN_END     = 12'hF00;
endpackage

// File: rtl/irqd_line_sense.sv
module irqd_line_sense #(
    parameter int NUM_EXT = 32
) (
    input  logic [NUM_EXT-1:0] ext_i,
    input  logic [NUM_EXT-1:0] level_i,
    output logic [NUM_EXT-1:0] rise_o,
    output logic [NUM_EXT-1:0] fall_o
);
    assign rise_o = ext_i & ~level_i;
    assign fall_o = ~ext_i & level_i;
endmodule

// File: rtl/irqd_swint_dec.sv
module irqd_swint_dec
    import irqd_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int CPU_W   = 1
) (
    input  logic [25:16]       ctl_i,
    input  logic [CPU_W-1:0]   cpu_i,
    output logic [NUM_CPU-1:0] mask_o
);
    localparam logic [NUM_CPU-1:0] ALL_CPUS = '1;

    sw_filter_t           filt;
    logic [NUM_CPU-1:0]   self_bit;

    assign filt     = sw_filter_t'(ctl_i[25:24]);
    assign self_bit = NUM_CPU'(1) << cpu_i;

    always_comb begin
        unique case (filt)
            FLT_LIST:   mask_o = ctl_i[16 +: NUM_CPU];
            FLT_OTHERS: mask_o = ALL_CPUS & ~self_bit;
            FLT_SELF:   mask_o = self_bit;
            FLT_ALL:    mask_o = ALL_CPUS;
            default:    mask_o = '0;
        endcase
    end
endmodule

// File: rtl/irqd_rd_lane.sv
module irqd_rd_lane
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    parameter int CPU_W   = 1
) (
    input  logic [11:0]                  off_i,
    input  logic [CPU_W-1:0]             cpu_i,
    input  logic                         dist_en_i,
    input  logic [NUM_CPU*NUM_IRQ-1:0]   en_i,
    input  logic [NUM_CPU*NUM_IRQ-1:0]   pend_i,
    input  logic [NUM_CPU*NUM_IRQ-1:0]   act_i,
    input  logic [NUM_CPU*NUM_IRQ*8-1:0] prio_i,
    input  logic [NUM_IRQ*NUM_CPU-1:0]   tgt_i,
    input  logic [NUM_IRQ-1:0]           model_i,
    input  logic [NUM_IRQ-1:0]           edge_i,
    output logic [7:0]                   rd_o,
    output logic                         bad_o
);
    localparam logic [7:0] GEOM = 8'(NUM_IRQ / 32 - 1) | 8'((NUM_CPU - 1) << 5);

    // Private view below ID 32, OR across CPUs above.
    function automatic logic banked(input logic [NUM_CPU*NUM_IRQ-1:0] vec,
                                    input int id, input int me);
        logic r;
        r = 1'b0;
        if (id < 32) r = vec[me*NUM_IRQ + id];
        else for (int c = 0; c < NUM_CPU; c++) r = r | vec[c*NUM_IRQ + id];
        return r;
    endfunction

    always_comb begin
        int base;
        int me;
        me    = int'(cpu_i);
        base  = 0;
        rd_o  = '0;
        bad_o = 1'b0;
        if (off_i < WIN_ENABLE) begin
            case (off_i)
                12'h000: rd_o = {7'b0, dist_en_i};
                12'h004: rd_o = GEOM;
                12'h001, 12'h002, 12'h003,
                12'h005, 12'h006, 12'h007: rd_o = '0;
                default: bad_o = 1'b1;
            endcase
        end else if (off_i < WIN_PENDING) begin
            base = int'(off_i[6:0]) * 8;
            if (base >= NUM_IRQ) bad_o = 1'b1;
            else for (int i = 0; i < 8; i++) rd_o[i] = banked(en_i, base + i, me);
        end else if (off_i < WIN_ACTIVE) begin
            base = int'(off_i[6:0]) * 8;
            if (base >= NUM_IRQ) bad_o = 1'b1;
            else for (int i = 0; i < 8; i++) rd_o[i] = banked(pend_i, base + i, me);
        end else if (off_i < WIN_PRIO) begin
            base = int'(off_i[7:0]) * 8;
            if (base >= NUM_IRQ) bad_o = 1'b1;
            else for (int i = 0; i < 8; i++) rd_o[i] = banked(act_i, base + i, me);
        end else if (off_i < WIN_TARGET) begin
            base = int'(off_i) - int'(WIN_PRIO);
            if (base >= NUM_IRQ) bad_o = 1'b1;
            else rd_o = prio_i[(me*NUM_IRQ + base)*8 +: 8];
        end else if (off_i < WIN_CONFIG) begin
            base = int'(off_i) - int'(WIN_TARGET);
            if (base >= NUM_IRQ) bad_o = 1'b1;
            else if (base >= 29 && base < 32) rd_o[me] = 1'b1;
            else rd_o[NUM_CPU-1:0] = tgt_i[base*NUM_CPU +: NUM_CPU];
        end else if (off_i < WIN_END) begin
            base = (int'(off_i) - int'(WIN_CONFIG)) * 4;
            if (base >= NUM_IRQ) bad_o = 1'b1;
            else for (int i = 0; i < 4; i++) begin
                rd_o[2*i]   = model_i[base + i];
                rd_o[2*i+1] = edge_i[base + i];
            end
        end else begin
            bad_o = 1'b1;
        end
    end
endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int NUM_EXT = NUM_IRQ - 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic                         req_word,
    input  logic [11:0]                  req_addr,
    input  logic [31:0]                  req_wdata,
    input  logic [CPU_W-1:0]             req_cpu,
    output logic                         req_ready,
    output logic                         rsp_valid,
    output logic [31:0]                  rsp_rdata,
    output logic                         rsp_err,
    input  logic [NUM_EXT-1:0]           ext_irq,
    input  logic [NUM_CPU*NUM_IRQ-1:0]   active_i,
    output logic                         dist_en_o,
    output logic [NUM_CPU*NUM_IRQ-1:0]   enable_o,
    output logic [NUM_CPU*NUM_IRQ-1:0]   pending_o,
    output logic [NUM_CPU*NUM_IRQ*8-1:0] prio_o,
    output logic [NUM_IRQ*NUM_CPU-1:0]   target_o,
    output logic [NUM_IRQ-1:0]           model_o,
    output logic [NUM_IRQ-1:0]           edge_o
);
    localparam int NI = NUM_IRQ;
    localparam int NC = NUM_CPU;

    acc_state_t state_q, state_d;
    logic                 dist_en_q, dist_en_d;
    logic [NC*NI-1:0]     en_q, en_d, pend_q, pend_d;
    logic [NC*NI*8-1:0]   prio_q, prio_d;
    logic [NI*NC-1:0]     tgt_q, tgt_d;
    logic [NI-1:0]        model_q, model_d, edge_q, edge_d;
    logic [NUM_EXT-1:0]   level_q, level_d, ext_rise, ext_fall;
    logic [31:0]          rdata_q;
    logic                 err_q;

    logic                 accept, is_swint, err_w;
    logic [NC-1:0]        sw_mask;
    logic [3:0]           lane_bad;
    logic [3:0][11:0]     lane_off;
    logic [3:0][7:0]      lane_rd;

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign is_swint = req_word && req_write && (req_addr[11:2] == OFF_SWINT[11:2]);
    assign err_w    = !is_swint && (lane_bad[0] || (req_word && (|lane_bad[3:1])));

    irqd_line_sense #(.NUM_EXT(NUM_EXT)) u_sense (
        .ext_i(ext_irq), .level_i(level_q), .rise_o(ext_rise), .fall_o(ext_fall));

    irqd_swint_dec #(.NUM_CPU(NC), .CPU_W(CPU_W)) u_swint (
        .ctl_i(req_wdata[25:16]), .cpu_i(req_cpu), .mask_o(sw_mask));

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign lane_off[g] = req_word ? {req_addr[11:2], 2'(g)}
                                      : ((g == 0) ? req_addr : 12'h000);
        irqd_rd_lane #(.NUM_IRQ(NI), .NUM_CPU(NC), .CPU_W(CPU_W)) u_rd (
            .off_i(lane_off[g]), .cpu_i(req_cpu), .dist_en_i(dist_en_q),
            .en_i(en_q), .pend_i(pend_q), .act_i(active_i), .prio_i(prio_q),
            .tgt_i(tgt_q), .model_i(model_q), .edge_i(edge_q),
            .rd_o(lane_rd[g]), .bad_o(lane_bad[g]));
    end

    // Next-state of the register file: accepted write first, then input lines.
    always_comb begin
        int base, id, me;
        logic [7:0] vv;
        dist_en_d = dist_en_q; en_d = en_q; pend_d = pend_q; prio_d = prio_q;
        tgt_d = tgt_q; model_d = model_q; edge_d = edge_q; level_d = level_q;
        me = int'(req_cpu); base = 0; id = 0; vv = '0;
        if (accept && is_swint) begin
            for (int c = 0; c < NC; c++)
                if (sw_mask[c] && int'(req_wdata[9:0]) < NI)
                    pend_d[c*NI + int'(req_wdata[9:0])] = 1'b1;
        end else if (accept && req_write) begin
            for (int ln = 0; ln < 4; ln++) begin
                if ((ln == 0 || req_word) && !lane_bad[ln]) begin
                    vv = req_wdata[8*ln +: 8];
                    if (lane_off[ln] == 12'h000) begin
                        dist_en_d = vv[0];
                    end else if (lane_off[ln] >= WIN_ENABLE && lane_off[ln] < WIN_PENDING) begin
                        base = int'(lane_off[ln][6:0]) * 8;
                        for (int i = 0; i < 8; i++) begin
                            id = base + i;
                            if (!lane_off[ln][7]) begin
                                if (id < 16 || vv[i]) begin
                                    if (id < 32) en_d[me*NI + id] = 1'b1;
                                    else for (int c = 0; c < NC; c++) en_d[c*NI + id] = 1'b1;
                                    if (id >= 32 && level_q[id-32] && !edge_q[id])
                                        for (int c = 0; c < NC; c++)
                                            if (tgt_q[id*NC + c]) pend_d[c*NI + id] = 1'b1;
                                end
                            end else if (id >= 16 && vv[i]) begin
                                if (id < 32) en_d[me*NI + id] = 1'b0;
                                else for (int c = 0; c < NC; c++) en_d[c*NI + id] = 1'b0;
                            end
                        end
                    end else if (lane_off[ln] >= WIN_PENDING && lane_off[ln] < WIN_ACTIVE) begin
                        base = int'(lane_off[ln][6:0]) * 8;
                        for (int i = 0; i < 8; i++) begin
                            id = base + i;
                            if (vv[i] && lane_off[ln][7])
                                for (int c = 0; c < NC; c++) pend_d[c*NI + id] = 1'b0;
                            else if (vv[i] && id >= 16 && id < 32)
                                pend_d[me*NI + id] = 1'b1;
                            else if (vv[i] && id >= 32)
                                for (int c = 0; c < NC; c++)
                                    if (tgt_q[id*NC + c]) pend_d[c*NI + id] = 1'b1;
                        end
                    end else if (lane_off[ln] >= WIN_PRIO && lane_off[ln] < WIN_TARGET) begin
                        id = int'(lane_off[ln]) - int'(WIN_PRIO);
                        if (id < 32) prio_d[(me*NI + id)*8 +: 8] = vv;
                        else for (int c = 0; c < NC; c++) prio_d[(c*NI + id)*8 +: 8] = vv;
                    end else if (lane_off[ln] >= WIN_TARGET && lane_off[ln] < WIN_CONFIG) begin
                        id = int'(lane_off[ln]) - int'(WIN_TARGET);
                        if (id < 29)      tgt_d[id*NC +: NC] = '0;
                        else if (id < 32) tgt_d[id*NC +: NC] = '1;
                        else              tgt_d[id*NC +: NC] = vv[NC-1:0];
                    end else if (lane_off[ln] >= WIN_CONFIG && lane_off[ln] < WIN_END) begin
                        base = (int'(lane_off[ln]) - int'(WIN_CONFIG)) * 4;
                        if (base < 32) vv = vv | 8'hAA;
                        for (int i = 0; i < 4; i++) begin
                            model_d[base + i] = vv[2*i];
                            edge_d[base + i]  = vv[2*i+1];
                        end
                    end
                end
            end
        end
        for (int j = 0; j < NUM_EXT; j++) begin
            if (ext_rise[j]) begin
                level_d[j] = 1'b1;
                if (edge_d[32+j] || (|(en_d & (NC*NI)'(1) << (32+j))))
                    for (int c = 0; c < NC; c++)
                        if (tgt_d[(32+j)*NC + c]) pend_d[c*NI + 32 + j] = 1'b1;
            end else if (ext_fall[j]) begin
                level_d[j] = 1'b0;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dist_en_q <= 1'b0;
            en_q      <= '0;
            for (int c = 0; c < NC; c++) en_q[c*NI +: 16] <= '1;
            pend_q    <= '0;
            prio_q    <= '0;
            tgt_q     <= '0;
            model_q   <= '0;
            edge_q    <= NI'(16'hFFFF);
            level_q   <= '0;
            rdata_q   <= '0;
            err_q     <= 1'b0;
        end else begin
            dist_en_q <= dist_en_d;
            en_q      <= en_d;
            pend_q    <= pend_d;
            prio_q    <= prio_d;
            tgt_q     <= tgt_d;
            model_q   <= model_d;
            edge_q    <= edge_d;
            level_q   <= level_d;
            if (accept) begin
                rdata_q <= req_word ? {lane_rd[3], lane_rd[2], lane_rd[1], lane_rd[0]}
                                    : {24'h0, lane_rd[0]};
                err_q   <= err_w;
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_rdata = rsp_valid ? rdata_q : '0;
    assign rsp_err   = rsp_valid && err_q;
    assign dist_en_o = dist_en_q;
    assign enable_o  = en_q;
    assign pending_o = pend_q;
    assign prio_o    = prio_q;
    assign target_o  = tgt_q;
    assign model_o   = model_q;
    assign edge_o    = edge_q;

    assert_resp_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));
    assert_accept_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    for (genvar c = 0; c < NC; c++) begin : g_cpu_chk
        assert_low_ids_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
            en_q[c*NI +: 16] == 16'hFFFF);
    end
    assert_low_ids_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_q[15:0] == 16'hFFFF);
    assert_low_targets_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_q[29*NC-1:0] == '0);

    for (genvar j = 0; j < NUM_EXT; j++) begin : g_ext_chk
        logic [NC-1:0] pend_col;
        for (genvar c = 0; c < NC; c++) begin : g_col
            assign pend_col[c] = pend_q[c*NI + 32 + j];
        end
        assert_edge_rise_pends_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!accept && ext_irq[j] && !level_q[j] && edge_q[32+j])
            |=> ((tgt_q[(32+j)*NC +: NC] & ~pend_col) == '0));
    end
endmodule

// File: tb/tb_irq_dist_regs.sv
`timescale 1ns/1ps
module tb_irq_dist_regs;
    localparam int NI = 64;
    localparam int NC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [0:0]  req_cpu = '0;
    logic req_ready, rsp_valid, rsp_err, dist_en_o;
    logic [31:0] rsp_rdata;
    logic [NI-33:0] ext_irq = '0;
    logic [NC*NI-1:0] active_i = '0;
    logic [NC*NI-1:0] enable_o, pending_o;
    logic [NC*NI*8-1:0] prio_o;
    logic [NI*NC-1:0] target_o;
    logic [NI-1:0] model_o, edge_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_dist_regs #(.NUM_IRQ(NI), .NUM_CPU(NC)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_cpu(req_cpu), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .ext_irq(ext_irq),
        .active_i(active_i), .dist_en_o(dist_en_o), .enable_o(enable_o),
        .pending_o(pending_o), .prio_o(prio_o), .target_o(target_o),
        .model_o(model_o), .edge_o(edge_o));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic wd, input logic [11:0] a,
                       input logic [31:0] d, input int c,
                       output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = wd;
        req_addr = a; req_wdata = d; req_cpu = 1'(c);
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata; er = rsp_err;
    endtask

    task automatic rd_chk(input string tag, input logic wd, input logic [11:0] a,
                          input int c, input logic [31:0] exp, input logic exp_err);
        logic [31:0] r; logic e;
        acc(1'b0, wd, a, 32'h0, c, r, e);
        chk(tag, r, exp);
        chk({tag, " err"}, 32'(e), 32'(exp_err));
    endtask

    task automatic wr(input logic wd, input logic [11:0] a, input logic [31:0] d, input int c);
        logic [31:0] r; logic e;
        acc(1'b1, wd, a, d, c, r, e);
    endtask

    task automatic t_reset;
        chk("R2 reset dist_en", 32'(dist_en_o), 0);
        rd_chk("R3 reset enables word", 1, 12'h100, 0, 32'h0000FFFF, 0);
        rd_chk("R8 reset config ids0-15", 1, 12'hC00, 1, 32'hAAAAAAAA, 0);
        rd_chk("R8 reset config ids16-19", 0, 12'hC04, 0, 32'h0, 0);
        rd_chk("R2 geometry", 1, 12'h004, 0, 32'h00000021, 0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        chk("R1 ready idle", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = 1'b0; req_word = 1'b0; req_addr = 12'h004; req_cpu = 0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 rsp_valid", 32'(rsp_valid), 1);
        chk("R1 ready low in resp", 32'(req_ready), 0);
        chk("R1 byte data", rsp_rdata, 32'h21);
        @(negedge clk);
        chk("R1 rsp one cycle", 32'(rsp_valid), 0);
    endtask

    task automatic t_dist;
        wr(0, 12'h000, 32'h1, 0);
        rd_chk("R2 enable readback", 0, 12'h000, 1, 32'h1, 0);
        chk("R2 dist_en_o", 32'(dist_en_o), 1);
        wr(0, 12'h002, 32'hFF, 0);
        rd_chk("R2 reserved byte", 0, 12'h002, 0, 32'h0, 0);
    endtask

    task automatic t_enable;
        wr(0, 12'h104, 32'h05, 0);
        rd_chk("R3 shared enable", 0, 12'h104, 1, 32'h05, 0);
        wr(0, 12'h102, 32'h01, 0);
        rd_chk("R3 private enable own", 0, 12'h102, 0, 32'h01, 0);
        rd_chk("R3 private enable other", 0, 12'h102, 1, 32'h00, 0);
        wr(0, 12'h180, 32'hFF, 0);
        rd_chk("R3 ids0-7 not cleared", 0, 12'h100, 0, 32'hFF, 0);
        wr(0, 12'h184, 32'h01, 1);
        rd_chk("R3 clear id32", 0, 12'h104, 0, 32'h04, 0);
    endtask

    task automatic t_prio;
        wr(0, 12'h410, 32'hA0, 1);
        rd_chk("R6 private prio own", 0, 12'h410, 1, 32'hA0, 0);
        rd_chk("R6 private prio other", 0, 12'h410, 0, 32'h00, 0);
        wr(0, 12'h428, 32'h30, 0);
        rd_chk("R6 shared prio", 0, 12'h428, 1, 32'h30, 0);
    endtask

    task automatic t_target;
        wr(0, 12'h805, 32'hFF, 0);
        rd_chk("R7 low id target zero", 0, 12'h805, 0, 32'h0, 0);
        wr(0, 12'h81E, 32'h00, 1);
        rd_chk("R7 id30 cpu1", 0, 12'h81E, 1, 32'h02, 0);
        rd_chk("R7 id30 cpu0", 0, 12'h81E, 0, 32'h01, 0);
        chk("R7 id30 stores all", 32'(target_o[30*NC +: NC]), 32'h3);
        wr(0, 12'h820, 32'hFF, 0);
        rd_chk("R7 id32 masked", 0, 12'h820, 0, 32'h03, 0);
    endtask

    task automatic t_config;
        wr(0, 12'hC00, 32'h00, 0);
        rd_chk("R8 low edge forced", 0, 12'hC00, 0, 32'hAA, 0);
        wr(0, 12'hC08, 32'h06, 0);
        rd_chk("R8 id32-35 config", 0, 12'hC08, 0, 32'h06, 0);
        chk("R8 edge_o id32", 32'(edge_o[32]), 1);
        chk("R8 model_o id33", 32'(model_o[33]), 1);
    endtask

    task automatic t_ext;
        @(negedge clk); ext_irq[0] = 1'b1;
        @(negedge clk);
        chk("R9 rise both targets", 32'(pending_o[32]) + 32'(pending_o[NI+32]), 2);
        wr(0, 12'h284, 32'h01, 0);
        repeat (3) @(negedge clk);
        rd_chk("R9 held high no retrigger", 0, 12'h204, 0, 32'h00, 0);
        ext_irq[0] = 1'b0;
        @(negedge clk); ext_irq[0] = 1'b1;
        @(negedge clk); ext_irq[0] = 1'b0;
        @(negedge clk);
        rd_chk("R9 fall keeps pending", 0, 12'h204, 1, 32'h01, 0);
        ext_irq[2] = 1'b1;
        @(negedge clk);
        rd_chk("R9 no target no pending", 0, 12'h204, 0, 32'h01, 0);
    endtask

    task automatic t_level_enable;
        wr(0, 12'h284, 32'hFF, 0);
        wr(0, 12'h822, 32'h01, 0);
        wr(0, 12'h104, 32'h04, 0);
        rd_chk("R4 level enable pends", 0, 12'h204, 1, 32'h04, 0);
        chk("R4 cpu0 pending", 32'(pending_o[34]), 1);
        chk("R4 cpu1 not target", 32'(pending_o[NI+34]), 0);
    endtask

    task automatic t_swint;
        wr(0, 12'h280, 32'hFF, 0);
        wr(1, 12'hF00, 32'h0002_0003, 0);
        chk("R10 list filter cpu0", 32'(pending_o[7:0]), 32'h00);
        chk("R10 list filter cpu1", 32'(pending_o[NI +: 8]), 32'h08);
        wr(1, 12'hF00, 32'h0100_0004, 0);
        chk("R10 others filter", 32'(pending_o[NI +: 8]), 32'h18);
        wr(1, 12'hF00, 32'h0200_0005, 1);
        chk("R10 self filter", 32'(pending_o[NI +: 8]), 32'h38);
        wr(1, 12'hF00, 32'h0300_0006, 0);
        rd_chk("R10 all filter cpu0", 0, 12'h200, 0, 32'h40, 0);
        rd_chk("R10 all filter cpu1", 0, 12'h200, 1, 32'h78, 0);
        wr(0, 12'h200, 32'h01, 0);
        chk("R5 set pending id0 ignored", 32'(pending_o[7:0]), 32'h40);
        wr(0, 12'h202, 32'h01, 1);
        rd_chk("R5 set pending id16 own", 0, 12'h202, 1, 32'h01, 0);
        rd_chk("R5 set pending id16 other", 0, 12'h202, 0, 32'h00, 0);
    endtask

    task automatic t_active;
        active_i[NI + 2] = 1'b1;
        active_i[40] = 1'b1;
        rd_chk("R11 active private cpu1", 0, 12'h300, 1, 32'h04, 0);
        rd_chk("R11 active private cpu0", 0, 12'h300, 0, 32'h00, 0);
        rd_chk("R11 active shared", 0, 12'h305, 1, 32'h01, 0);
        wr(0, 12'h300, 32'hFF, 1);
        rd_chk("R11 write ignored", 0, 12'h300, 1, 32'h04, 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] r; logic e;
        rd_chk("R12 gap read", 1, 12'h008, 0, 32'h0, 1);
        acc(1'b1, 0, 12'h108, 32'hFF, 0, r, e);
        chk("R12 out-of-range write err", 32'(e), 1);
        rd_chk("R12 out-of-range read", 0, 12'h108, 0, 32'h0, 1);
        acc(1'b1, 0, 12'hF00, 32'h07, 0, r, e);
        chk("R12 byte swint err", 32'(e), 1);
        chk("R12 byte swint no effect", 32'(pending_o[7:0]), 32'h40);
        wr(0, 12'hFE0, 32'h55, 0);
        rd_chk("R12 high offset", 0, 12'hFE0, 0, 32'h0, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_dist();
        t_enable();
        t_prio();
        t_target();
        t_config();
        t_ext();
        t_level_enable();
        t_swint();
        t_active();
        t_unmapped();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule